// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank SDRAM and drives the device from power-on to a usable state. Reset places it in a settle phase. In that phase it keeps clock-enable and the data mask high and presents a NOP on the command pins. The phase lasts for a wait computed from a clock-frequency parameter and a wait in microseconds, 200 µs by default. When the wait ends the block issues precharge-all, then a parameterized number of auto-refresh commands (two or more), then a mode register set and an optional extended mode register set. Between commands it inserts NOP gaps of programmable length. A parameter swaps the order so that the mode-set pair comes before the refreshes. After the final gap the block raises `init_done` and keeps driving NOPs until the memory controller takes over the pins.

Configuration inputs supply the burst length, burst type, CAS latency and write-burst mode for the main mode word. They also supply the partial-array self-refresh selection and the temperature-compensated refresh period for the extended word. These inputs are assumed to be held stable during initialization.

States: `ST_SETTLE` (reset wait) → `ST_PRE` (precharge-all) → `ST_WAIT_RP`. From there the next-step selector picks `ST_REF` → `ST_WAIT_RFC`, `ST_MRS` → `ST_WAIT_MRD` or `ST_EMRS` → `ST_WAIT_EMRD`, according to the order parameter and how far the sequence has gone. Once every step is done it moves to `ST_READY`, which is terminal until reset. Each wait state leaves on the cycle its gap timer reaches zero.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and throughout the settle phase, `cke` and `dqm` are 1, the command is NOP (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1) and `init_done` is 0.
- R2: After reset is released, exactly SETTLE_US×CLK_MHZ cycles of NOP occur before the first command, and that command is precharge-all.
- R3: Precharge-all is encoded as `cs_n,ras_n,cas_n,we_n` = 0,0,1,0 with `addr[10]` = 1.
- R4: Exactly REF_COUNT (at least 2) auto-refresh commands are issued, encoded 0,0,0,1, and each is followed by T_RFC cycles before the next command.
- R5: The next command comes T_RP cycles after precharge-all and T_MRD cycles after each mode-register write. Every command cycle is followed by a NOP cycle.
- R6: The main mode write is encoded 0,0,0,0 with `ba` = 00. Its address word carries `addr[2:0]` = burst length, `addr[3]` = burst type, `addr[6:4]` = CAS latency and `addr[9]` = write-burst mode; `addr[8:7]` and `addr[11:10]` are 0.
- R7: When EXT_EN=1, an extended mode write (0,0,0,0) follows the main one with `ba` = 10 (bit 1 set, bit 0 clear). Its address word carries `addr[2:0]` = partial-array selection and `addr[4:3]` = refresh-period setting, with all other bits 0.
- R8: With MODE_FIRST=0 the order is precharge, refreshes, main mode, extended mode. With MODE_FIRST=1 it is precharge, main mode, extended mode, refreshes.
- R9: `init_done` rises exactly one closing gap (T_MRD after a mode write, T_RFC after a refresh) after the last command. It then stays 1 with NOP commands and `cke` high.
- R10: Asserting reset in the middle of the sequence returns the block to the R1 state, and the whole sequence restarts from the settle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the main mode word |
| cfg_burst_type | input | 1 | Burst type bit |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_wr_burst | input | 1 | Write-burst mode bit |
| cfg_pasr | input | 3 | Partial-array self-refresh selection |
| cfg_tcsr | input | 2 | Self-refresh period setting |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| ba | output | 2 | Bank select |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The case hardest to reach from the ports is a reset arriving partway through the command phase. Getting there takes tens of thousands of NOP cycles before the first command appears. The stimulus waits for the full 200 µs settle of the default instance. It then tracks the command count that the bench has observed, asserts reset as soon as the second command has been seen, and checks that the settle count starts again from zero. A second instance, with a short settle and the swapped order, runs beside the first under the same directed and seeded-random configuration words. This exercises both orderings and the closing gap that follows a refresh.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_SETTLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_EMRS,
        ST_WAIT_EMRD,
        ST_READY
    } init_state_e;

    // command bits ordered {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int          W         = 16,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= RESET_VAL;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign zero = (count_q == '0);

    // timer never wraps: once at zero it stays until reloaded (R5)
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_init_words.sv
module sdram_init_words #(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    input  logic              wr_burst,
    input  logic [2:0]        pasr,
    input  logic [1:0]        tcsr,
    output logic [ADDR_W-1:0] mode_word,
    output logic [ADDR_W-1:0] ext_word
);
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_len;
        mode_word[3]   = burst_type;
        mode_word[6:4] = cas_lat;
        mode_word[9]   = wr_burst;
        ext_word       = '0;
        ext_word[2:0]  = pasr;
        ext_word[4:3]  = tcsr;
    end

    // reserved bits of the main word stay low (R6)
    p_reserved_low_r6: assert final (mode_word[8:7] == 2'b00
                                     && mode_word[ADDR_W-1:10] == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int SETTLE_US  = 200,
    parameter int REF_COUNT  = 2,
    parameter int T_RP       = 3,
    parameter int T_RFC      = 7,
    parameter int T_MRD      = 2,
    parameter bit MODE_FIRST = 1'b0,
    parameter bit EXT_EN     = 1'b1,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_wr_burst,
    input  logic [2:0]        cfg_pasr,
    input  logic [1:0]        cfg_tcsr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              dqm,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int TW         = $clog2(SETTLE_CYC + 1) + 1;
    localparam int RW         = $clog2(REF_COUNT + 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [RW-1:0] REF_LAST  = RW'(REF_COUNT);

    init_state_e state_q, state_d, step_sel;
    logic [RW-1:0] ref_cnt_q;
    logic          mrs_done_q, emrs_done_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [ADDR_W-1:0] mode_word, ext_word;
    logic [3:0]    cmd;

    sdram_init_timer #(.W(TW), .RESET_VAL(SETTLE_LD)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    sdram_init_words #(.ADDR_W(ADDR_W)) u_words (
        .burst_len(cfg_burst_len), .burst_type(cfg_burst_type),
        .cas_lat(cfg_cas_lat), .wr_burst(cfg_wr_burst),
        .pasr(cfg_pasr), .tcsr(cfg_tcsr),
        .mode_word(mode_word), .ext_word(ext_word)
    );

    // next step after any gap, chosen by order parameter and progress
    generate
        if (MODE_FIRST) begin : g_mode_first
            always_comb begin
                if (!mrs_done_q)                 step_sel = ST_MRS;
                else if (EXT_EN && !emrs_done_q) step_sel = ST_EMRS;
                else if (ref_cnt_q != REF_LAST)  step_sel = ST_REF;
                else                             step_sel = ST_READY;
            end
        end else begin : g_refresh_first
            always_comb begin
                if (ref_cnt_q != REF_LAST)       step_sel = ST_REF;
                else if (!mrs_done_q)            step_sel = ST_MRS;
                else if (EXT_EN && !emrs_done_q) step_sel = ST_EMRS;
                else                             step_sel = ST_READY;
            end
        end
    endgenerate

    // state register and progress flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SETTLE;
            ref_cnt_q   <= '0;
            mrs_done_q  <= 1'b0;
            emrs_done_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REF)  ref_cnt_q   <= ref_cnt_q + 1'b1;
            if (state_q == ST_MRS)  mrs_done_q  <= 1'b1;
            if (state_q == ST_EMRS) emrs_done_q <= 1'b1;
        end
    end

    // transitions and gap loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_SETTLE:    if (tmr_zero) state_d = ST_PRE;
            ST_PRE:       begin state_d = ST_WAIT_RP;   tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);  end
            ST_REF:       begin state_d = ST_WAIT_RFC;  tmr_load = 1'b1; tmr_val = TW'(T_RFC - 2); end
            ST_MRS:       begin state_d = ST_WAIT_MRD;  tmr_load = 1'b1; tmr_val = TW'(T_MRD - 2); end
            ST_EMRS:      begin state_d = ST_WAIT_EMRD; tmr_load = 1'b1; tmr_val = TW'(T_MRD - 2); end
            ST_WAIT_RP,
            ST_WAIT_RFC,
            ST_WAIT_MRD,
            ST_WAIT_EMRD: if (tmr_zero) state_d = step_sel;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_SETTLE;
        endcase
    end

    // outputs from state
    always_comb begin
        cmd       = CMD_NOP;
        ba        = 2'b00;
        addr      = '0;
        cke       = 1'b1;
        dqm       = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            ST_PRE:   begin cmd = CMD_PRE; addr[10] = 1'b1; end
            ST_REF:   cmd = CMD_REF;
            ST_MRS:   begin cmd = CMD_MRS; addr = mode_word; end
            ST_EMRS:  begin cmd = CMD_MRS; ba = 2'b10; addr = ext_word; end
            ST_READY: init_done = 1'b1;
            default:  ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // ---------------- assertions ----------------
    p_cmd_then_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[10]);

    p_first_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SETTLE && state_q != ST_SETTLE) |-> (state_q == ST_PRE));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && cke && {cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    p_refresh_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ref_cnt_q == REF_LAST));

    generate
        if (!MODE_FIRST) begin : g_chk_order
            p_mode_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ({cs_n, ras_n, cas_n, we_n} == CMD_MRS) |-> (ref_cnt_q == REF_LAST));
        end else begin : g_chk_order_swap
            p_ref_after_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ({cs_n, ras_n, cas_n, we_n} == CMD_REF) |-> (mrs_done_q && (emrs_done_q || !EXT_EN)));
        end
    endgenerate

    p_settle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (cke && dqm && !init_done && cs_n == 1'b0 && ras_n && cas_n && we_n));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    localparam int NREF   = 2;
    localparam int TRP    = 3;
    localparam int TRFC   = 7;
    localparam int TMRD   = 2;
    localparam int STEPS  = NREF + 3;
    localparam int KNOP = 0, KPRE = 1, KREF = 2, KMRS = 3, KEXT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] bl = '0, cl = '0, pasr = '0;
    logic bt = 1'b0, wb = 1'b0;
    logic [1:0] tcsr = '0;

    logic cs0, ras0, cas0, we0, cke0, dqm0, dn0;
    logic [1:0] ba0;
    logic [11:0] ad0;
    logic cs1, ras1, cas1, we1, cke1, dqm1, dn1;
    logic [1:0] ba1;
    logic [11:0] ad1;

    int checks = 0;
    int fails  = 0;
    int cyc[2], step[2], last_c[2], last_k[2];
    bit done_seen[2];
    int settle_of[2] = '{20000, 200};

    always #5 clk = ~clk;

    sdram_init_seq #(.REF_COUNT(NREF), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
                     .MODE_FIRST(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_wr_burst(wb), .cfg_pasr(pasr), .cfg_tcsr(tcsr),
        .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .cke(cke0), .dqm(dqm0),
        .ba(ba0), .addr(ad0), .init_done(dn0));

    sdram_init_seq #(.SETTLE_US(2), .REF_COUNT(NREF), .T_RP(TRP), .T_RFC(TRFC),
                     .T_MRD(TMRD), .MODE_FIRST(1'b1)) u_dut_swap (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_wr_burst(wb), .cfg_pasr(pasr), .cfg_tcsr(tcsr),
        .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .cke(cke1), .dqm(dqm1),
        .ba(ba1), .addr(ad1), .init_done(dn1));

    function automatic int exp_kind(int id, int s);
        if (s == 0) return KPRE;
        if (id == 0) begin
            if (s <= NREF) return KREF;
            return (s == NREF + 1) ? KMRS : KEXT;
        end
        if (s == 1) return KMRS;
        if (s == 2) return KEXT;
        return KREF;
    endfunction

    function automatic int gap_after(int k);
        case (k)
            KPRE:    return TRP;
            KREF:    return TRFC;
            default: return TMRD;
        endcase
    endfunction

    function automatic int kind_of(logic [3:0] c, logic [1:0] b);
        case (c)
            4'b0111: return KNOP;
            4'b0010: return KPRE;
            4'b0001: return KREF;
            4'b0000: return (b == 2'b10) ? KEXT : KMRS;
            default: return -1;
        endcase
    endfunction

    function automatic logic [11:0] exp_mode();
        return {2'b00, wb, 2'b00, cl, bt, bl};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic observe(int id, logic [3:0] c, logic [1:0] b, logic [11:0] a,
                           logic ck, logic dm, logic dn);
        int k, g;
        if (!rst_n) begin
            cyc[id] = 0; step[id] = 0; last_c[id] = 0; last_k[id] = KNOP;
            done_seen[id] = 0;
            check(c == 4'b0111 && ck && dm && !dn, "R1/R10 reset pins",
                  {c, ck, dm, dn}, {4'b0111, 3'b110});
            return;
        end
        k = kind_of(c, b);
        if (!done_seen[id])
            check(ck && dm, "R1 cke/dqm high", {ck, dm}, 3);
        if (k != KNOP) begin
            if (done_seen[id]) check(0, "R9 command after done", k, KNOP);
            else begin
                g = (step[id] == 0) ? settle_of[id] : gap_after(last_k[id]);
                check(k == exp_kind(id, step[id]), "R8/R4 command order", k, exp_kind(id, step[id]));
                check(cyc[id] - last_c[id] == g, step[id] == 0 ? "R2 settle length" : "R5/R4 gap",
                      cyc[id] - last_c[id], g);
                if (k == KPRE) check(a[10], "R3 precharge A10", a[10], 1);
                if (k == KMRS) check(a == exp_mode() && b == 2'b00, "R6 mode word", a, exp_mode());
                if (k == KEXT) check(a == {7'b0, tcsr, pasr}, "R7 extended word", a, {7'b0, tcsr, pasr});
                last_c[id] = cyc[id]; last_k[id] = k; step[id]++;
            end
        end
        if (dn && !done_seen[id]) begin
            done_seen[id] = 1;
            check(step[id] == STEPS, "R9 step count at done", step[id], STEPS);
            check(cyc[id] - last_c[id] == gap_after(last_k[id]), "R9 done timing",
                  cyc[id] - last_c[id], gap_after(last_k[id]));
        end else if (!dn && done_seen[id]) check(0, "R9 done dropped", 0, 1);
        else if (dn) check(c == 4'b0111 && ck, "R9 idle after done", c, 4'b0111);
        cyc[id]++;
    endtask

    always @(negedge clk) begin
        observe(0, {cs0, ras0, cas0, we0}, ba0, ad0, cke0, dqm0, dn0);
        observe(1, {cs1, ras1, cas1, we1}, ba1, ad1, cke1, dqm1, dn1);
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic set_cfg(int mode);
        if (mode == 0) begin
            {bl, bt, cl, wb, pasr, tcsr} = '0;
        end else if (mode == 1) begin
            {bl, bt, cl, wb, pasr, tcsr} = '1;
        end else begin
            bl = 3'($urandom); bt = 1'($urandom); cl = 3'($urandom);
            wb = 1'($urandom); pasr = 3'($urandom); tcsr = 2'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int run = 0; run < 4; run++) begin
            set_cfg(run);
            do_reset();
            if (run == 2) begin
                // R10: reset once the second command has appeared
                wait (step[0] == 2);
                @(posedge clk);
                do_reset();
            end
            wait (dn0 && dn1);
            repeat (6) @(posedge clk);
            check(done_seen[0] && done_seen[1], "R9 both ready", done_seen[0] + done_seen[1], 2);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule